// File: doc/BRIEF.md
# Two-Wire Bus Monitor with Multi-Master Arbitration Check

This block watches the clock and data lines of a shared two-wire (I2C) bus on behalf of a multi-master controller. Both lines pass through two-stage synchronizers. The block then detects START and STOP conditions and keeps one sticky flag for each. From the two flags it derives a bus-free indication, which the controller uses to decide when it may take the bus. A STOP can also raise a single-cycle interrupt pulse, so a controller that is waiting for a busy bus learns when the bus is released.

While the local master drives the bus, the block checks arbitration. On every rising clock edge it compares the sampled data level with the level the master intends to drive. If the master has released the data line high but the line reads low, another master is holding it, and a sticky collision flag is set. The check runs only in the master phases where arbitration can be lost. Clock generation and byte shifting belong to the surrounding controller.

Top module: `i2c_bus_watch`

## Requirements
- R1: After synchronous reset, both condition flags and the collision flag are 0, bus_free is 1 and stop_irq is 0.
- R2: While enable is 0, the start and stop flags are held at 0 and bus_free is 1, even if conditions occur on the lines.
- R3: A START is data falling while the clock is high. Once synchronized, a START sets start_seen and clears stop_seen. The flags change on the third clock edge after the raw line changes.
- R4: A STOP is data rising while the clock is high. A STOP sets stop_seen and clears start_seen, with the same latency as a START.
- R5: bus_free is 1 exactly when stop_seen is 1, or when start_seen and stop_seen are both 0.
- R6: When stop_irq_en is 1, each detected STOP produces exactly one single-cycle pulse on stop_irq. No pulse is produced on a START, or on a STOP while stop_irq_en is 0.
- R7: Data transitions while the clock is low are not conditions and leave both flags unchanged.
- R8: The collision flag is set when all of the following hold at a synchronized rising clock edge: enable is 1, drive_en is 1, sda_expect is 1, the data line samples 0, and phase is one of 1 (START), 2 (repeated START), 3 (address), 4 (data) or 5 (acknowledge).
- R9: No collision is flagged in phases 0 (idle), 6 (stop) or 7 (receive). No collision is flagged when drive_en, sda_expect or enable is 0, or when the data line samples 1.
- R10: The collision flag stays set until coll_clr is pulsed. If a new collision occurs in the same cycle as coll_clr, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Monitor enable; when 0, clears the condition flags |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| drive_en | input | 1 | Local master is actively driving the bus |
| sda_expect | input | 1 | Data level the local master intends (1 = released) |
| phase | input | 3 | Current master phase, encoded as in R8/R9 |
| stop_irq_en | input | 1 | Enables the STOP interrupt pulse |
| coll_clr | input | 1 | Strobe that clears the collision flag |
| start_seen | output | 1 | Sticky START flag |
| stop_seen | output | 1 | Sticky STOP flag |
| bus_free | output | 1 | Bus may be claimed |
| stop_irq | output | 1 | One-cycle pulse on STOP |
| collision | output | 1 | Sticky arbitration-loss flag |

## Verification
The bench sweeps every combination of phase, drive_en, sda_expect and sampled data level. A design with a wrong phase set or inverted comparison would miss real arbitration losses or flag false collisions during receive and idle. It also toggles data while the clock is low, to catch a detector that ignores the clock level and reports spurious conditions. Further tests disable the block in the middle of a transfer, count interrupt pulses with the interrupt both enabled and masked, and hold a collision through idle cycles. Together these expose a flag that survives disable, an interrupt that fires more than once or fires on START, and a collision flag that clears by itself.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_RSTART = 3'd2,
        PH_ADDR   = 3'd3,
        PH_DATA   = 3'd4,
        PH_ACK    = 3'd5,
        PH_STOP   = 3'd6,
        PH_RECV   = 3'd7
    } mst_phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef struct packed {
        logic start_det;
        logic stop_det;
        logic scl_rise;
        logic sda_lvl;
    } bus_events_t;

    localparam int unsigned LINE_W = $bits(bus_lines_t);

    // Phases in which the local master can lose arbitration
    function automatic logic phase_checked(mst_phase_e p);
        return (p == PH_START) || (p == PH_RSTART) || (p == PH_ADDR) ||
               (p == PH_DATA)  || (p == PH_ACK);
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int unsigned STAGES    = 2,
    parameter int unsigned WIDTH     = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[s] <= {WIDTH{RESET_VAL}};
            end else if (s == 0) begin
                chain[s] <= d;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_cond_detect.sv
module i2cw_cond_detect
    import i2cw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_lines_t  lines,
    output bus_events_t ev
);
    bus_lines_t prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev <= lines;
        end
    end

    always_comb begin
        ev.start_det = prev.scl && lines.scl && prev.sda && !lines.sda;
        ev.stop_det  = prev.scl && lines.scl && !prev.sda && lines.sda;
        ev.scl_rise  = !prev.scl && lines.scl;
        ev.sda_lvl   = lines.sda;
    end
endmodule

// File: rtl/i2cw_arbiter.sv
module i2cw_arbiter
    import i2cw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       scl_rise,
    input  logic       sda_lvl,
    input  logic       drive_en,
    input  logic       sda_expect,
    input  mst_phase_e phase,
    input  logic       coll_clr,
    output logic       collision
);
    logic mismatch;

    assign mismatch = enable && drive_en && scl_rise && sda_expect && !sda_lvl &&
                      phase_checked(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            collision <= 1'b0;
        end else if (mismatch) begin
            collision <= 1'b1;
        end else if (coll_clr) begin
            collision <= 1'b0;
        end
    end

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (rst)
        collision && !coll_clr |=> collision); // R10
    AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(collision) |-> $past(scl_rise && !sda_lvl && sda_expect && drive_en)); // R8
    AST_COLL_QUIET_PHASE: assert property (@(posedge clk) disable iff (rst)
        !collision && (phase == PH_IDLE || phase == PH_STOP || phase == PH_RECV) |=> !collision); // R9
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2cw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       drive_en,
    input  logic       sda_expect,
    input  logic [2:0] phase,
    input  logic       stop_irq_en,
    input  logic       coll_clr,
    output logic       start_seen,
    output logic       stop_seen,
    output logic       bus_free,
    output logic       stop_irq,
    output logic       collision
);
    logic [LINE_W-1:0] raw_lines;
    logic [LINE_W-1:0] sync_lines;
    bus_lines_t        lines;
    bus_events_t       ev;

    assign raw_lines = {scl_in, sda_in};
    assign lines     = bus_lines_t'(sync_lines);

    i2cw_sync #(
        .STAGES   (SYNC_STAGES),
        .WIDTH    (LINE_W),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (sync_lines)
    );

    i2cw_cond_detect u_detect (
        .clk  (clk),
        .rst  (rst),
        .lines(lines),
        .ev   (ev)
    );

    i2cw_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .scl_rise  (ev.scl_rise),
        .sda_lvl   (ev.sda_lvl),
        .drive_en  (drive_en),
        .sda_expect(sda_expect),
        .phase     (mst_phase_e'(phase)),
        .coll_clr  (coll_clr),
        .collision (collision)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else if (ev.start_det) begin
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
        end else if (ev.stop_det) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_irq <= 1'b0;
        end else begin
            stop_irq <= enable && stop_irq_en && ev.stop_det;
        end
    end

    assign bus_free = stop_seen || !start_seen;

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !start_seen && !stop_seen && bus_free); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        enable && ev.start_det |=> start_seen && !stop_seen && !bus_free); // R3
    AST_STOP_FREE: assert property (@(posedge clk) disable iff (rst)
        enable && ev.stop_det |=> stop_seen && !start_seen && bus_free); // R4
    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (rst)
        !start_seen |-> bus_free); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stop_irq |=> !stop_irq); // R6
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        stop_irq |-> stop_seen); // R6
endmodule

// File: tb/test_i2c_bus_watch.sv
`timescale 1ns/1ps
module test_i2c_bus_watch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       drive_en = 1'b0;
    logic       sda_expect = 1'b1;
    logic [2:0] phase = 3'd0;
    logic       stop_irq_en = 1'b1;
    logic       coll_clr = 1'b0;
    logic       start_seen, stop_seen, bus_free, stop_irq, collision;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_bus_watch i_i2c_bus_watch (
        .clk(clk), .rst(rst), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
        .drive_en(drive_en), .sda_expect(sda_expect), .phase(phase),
        .stop_irq_en(stop_irq_en), .coll_clr(coll_clr),
        .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
        .stop_irq(stop_irq), .collision(collision)
    );

    always @(posedge clk) if (!rst && stop_irq) irq_cnt <= irq_cnt + 1;

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        coll_clr = 1'b1;
        step(1);
        coll_clr = 1'b0;
        step(1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base;
        step(3);
        rst = 1'b0;
        step(4);
        // R1 reset state
        chk("R1 start_seen", start_seen, 1'b0);
        chk("R1 stop_seen", stop_seen, 1'b0);
        chk("R1 bus_free", bus_free, 1'b1);
        chk("R1 collision", collision, 1'b0);
        chk("R1 stop_irq", stop_irq, 1'b0);

        // R3 START with clock high
        base = irq_cnt;
        sda_in = 1'b0;
        step(2);
        chk("R3 latency not yet", start_seen, 1'b0);
        step(1);
        chk("R3 start_seen", start_seen, 1'b1);
        chk("R3 stop_seen", stop_seen, 1'b0);
        chk("R5 busy", bus_free, 1'b0);
        chk_int("R6 no irq on START", irq_cnt, base);

        // R7 data toggles with clock low
        scl_in = 1'b0; step(4);
        sda_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        chk("R7 start kept", start_seen, 1'b1);
        chk("R7 stop kept", stop_seen, 1'b0);

        // R4 STOP with irq enabled
        scl_in = 1'b1; step(4);
        sda_in = 1'b1; step(4);
        chk("R4 stop_seen", stop_seen, 1'b1);
        chk("R4 start cleared", start_seen, 1'b0);
        chk("R5 free after STOP", bus_free, 1'b1);
        chk_int("R6 one irq", irq_cnt, base + 1);

        // R6 masked interrupt
        stop_irq_en = 1'b0;
        sda_in = 1'b0; step(4);
        sda_in = 1'b1; step(4);
        chk("R4 second stop", stop_seen, 1'b1);
        chk_int("R6 masked irq", irq_cnt, base + 1);
        stop_irq_en = 1'b1;

        // R2 disable clears flags
        sda_in = 1'b0; step(4);
        chk("R3 start again", start_seen, 1'b1);
        enable = 1'b0; step(2);
        chk("R2 start cleared", start_seen, 1'b0);
        chk("R2 stop clear", stop_seen, 1'b0);
        chk("R2 bus_free", bus_free, 1'b1);
        sda_in = 1'b1; step(4);
        sda_in = 1'b0; step(4);
        chk("R2 start held", start_seen, 1'b0);
        chk("R2 stop held", stop_seen, 1'b0);
        chk_int("R6 no irq while disabled", irq_cnt, base + 1);
        enable = 1'b1; step(2);
        sda_in = 1'b1; step(4);
        chk("R4 stop after re-enable", stop_seen, 1'b1);

        // R8/R9 exhaustive arbitration sweep
        scl_in = 1'b0; step(4);
        for (int ph = 0; ph < 8; ph++) begin
            for (int dv = 0; dv < 2; dv++) begin
                for (int ex = 0; ex < 2; ex++) begin
                    for (int sl = 0; sl < 2; sl++) begin
                        logic want;
                        pulse_clr();
                        phase = 3'(ph);
                        drive_en = dv[0];
                        sda_expect = ex[0];
                        sda_in = sl[0];
                        step(4);
                        scl_in = 1'b1;
                        step(4);
                        want = dv[0] && ex[0] && !sl[0] && (ph >= 1) && (ph <= 5);
                        chk(want ? "R8 collision" : "R9 no collision", collision, want);
                        scl_in = 1'b0;
                        step(4);
                    end
                end
            end
        end

        // R9 disabled block does not check
        pulse_clr();
        enable = 1'b0;
        phase = 3'd3; drive_en = 1'b1; sda_expect = 1'b1; sda_in = 1'b0;
        step(4);
        scl_in = 1'b1; step(4);
        chk("R9 disabled", collision, 1'b0);
        scl_in = 1'b0; step(4);
        enable = 1'b1;

        // R10 sticky until clear
        scl_in = 1'b1; step(4);
        chk("R8 set for sticky", collision, 1'b1);
        scl_in = 1'b0; drive_en = 1'b0; phase = 3'd0; step(12);
        chk("R10 held", collision, 1'b1);
        pulse_clr();
        chk("R10 cleared", collision, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule